// File: doc/BRIEF.md
# Prescaled two-channel PWM generator

This block produces one or two pulse-width modulated outputs. Each channel has its own clock enable and three registers on a small memory-mapped bus. Every channel first divides the input clock with a prescaler, which gives one scaled tick every (prescale+1) input clocks. A period counter then runs from 0 up to a programmed limit, so one period is (prescale+1)*(limit+1) input clocks. The output is high while the period count is below the duty value. A separate full-duty flag forces the output high for the whole period, whatever the duty value holds.

Settings written while a channel runs are not applied at once. They are copied into the working set only at the next period boundary, so a change of duty or period can never cut a pulse short. When software removes the enable, one control bit selects how the channel stops. In graceful mode the current period runs to its end. In abrupt mode the output falls and the counters clear on the very next clock edge.

The bus is a plain address, write data, write strobe and read data interface, with one 32-bit word per register. Reads are combinational. For each channel, the registers are at byte offsets 0x0 (control), 0x4 (duty) and 0x8 (period). Channel n starts at byte address 0x10*n.

Top module: `prescaled_pwm`

## Requirements
- R1: One output period lasts (P+1)*(V+1) input clock cycles. P is the control-register bits [5:0] and V is the period-register bits [9:0]. Periods repeat back to back while the enable is held high.
- R2: When D, the duty-register bits [9:0], lies between 1 and V, the output is high for the first (P+1)*D input cycles of each period and low for the rest.
- R3: When the full-duty flag (duty-register bit 10) is 1, the output is high for the whole period for any D, including D=0.
- R4: With the flag at 0, D=0 holds the output low and any D >= V+1 holds it high through every period.
- R5: When the shutdown-mode bit (control bit 6) is 0 and the enable is removed, the current period completes with its normal high time, and then the output stays low. No new period starts.
- R6: When the shutdown-mode bit is 1 and the enable is removed, the output is low from the first clock edge that samples the enable low. The counters clear, so the next enable starts a full-length period.
- R7: Duty, period and prescale values written while a channel runs take effect only at the next period boundary. The period in progress keeps the old values.
- R8: Registers read back what was written, through the following fields. Control: bits [5:0] prescale, bit 6 shutdown mode. Duty: bits [9:0] duty, bit 10 full flag. Period: bits [9:0] limit. All other bits read 0. Offset 0xC in a channel reads 0, and every register is 0 after reset.
- R9: Channel 1 uses the same layout at byte address 0x10. Each channel is independent of the other in its registers and its waveform.
- R10: After reset and while a channel has never been enabled, its output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, which is the source of all PWM timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| ch_en | input | NUM_CH (2) | Per-channel run enable |
| pwm_out | output | NUM_CH (2) | Per-channel PWM output |

## Verification
Latencies:
- A register write shows on bus_rdata in the cycle after the edge that samples the strobe.
- A channel's output follows an enable that arrives from idle at the next rising edge.
- In abrupt mode, a removed enable takes effect at the next rising edge.
- New settings appear only at the first period boundary after the write.

The bench drives and samples one time unit after each falling edge, so every observation lies between the edges at which these changes take place. A monitor measures the high and the whole length of each complete period from rising output to rising output. These measured lengths are compared with the formulas. For the shutdown and shadow-register cases, the bench counts high cycles over fixed windows, and it checks which period each measurement belongs to.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_DUTY   = 2'd1,
    REG_PERIOD = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // Output level for one scaled tick of the period
  function automatic logic duty_level(input logic [15:0] count,
                                      input logic [15:0] duty,
                                      input logic        full);
    return full | (count < duty);
  endfunction

  // Input cycles in one period
  function automatic int unsigned period_cycles(input int unsigned pre,
                                                input int unsigned lim);
    return (pre + 1) * (lim + 1);
  endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           wr_en,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_CH-1:0][PRE_W-1:0]   pre_o,
  output logic [NUM_CH-1:0]              sd_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   dc_o,
  output logic [NUM_CH-1:0]              full_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   pv_o
);

  localparam int SEL_W = ADDR_W - 4;

  logic [SEL_W-1:0] ch_sel;
  reg_sel_e         reg_sel;
  logic [NUM_CH-1:0] hit_ctrl, hit_duty, hit_period;

  assign ch_sel  = addr[ADDR_W-1:4];
  assign reg_sel = reg_sel_e'(addr[3:2]);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      hit_ctrl[c]   = wr_en && (ch_sel == SEL_W'(c)) && (reg_sel == REG_CTRL);
      hit_duty[c]   = wr_en && (ch_sel == SEL_W'(c)) && (reg_sel == REG_DUTY);
      hit_period[c] = wr_en && (ch_sel == SEL_W'(c)) && (reg_sel == REG_PERIOD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_o  <= '0;
      sd_o   <= '0;
      dc_o   <= '0;
      full_o <= '0;
      pv_o   <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hit_ctrl[c]) begin
          pre_o[c] <= wdata[PRE_W-1:0];
          sd_o[c]  <= wdata[PRE_W];
        end
        if (hit_duty[c]) begin
          dc_o[c]   <= wdata[CNT_W-1:0];
          full_o[c] <= wdata[CNT_W];
        end
        if (hit_period[c]) pv_o[c] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == SEL_W'(c)) begin
        case (reg_sel)
          REG_CTRL:   rdata = DATA_W'({sd_o[c], pre_o[c]});
          REG_DUTY:   rdata = DATA_W'({full_o[c], dc_o[c]});
          REG_PERIOD: rdata = DATA_W'(pv_o[c]);
          default:    rdata = '0;
        endcase
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CNT_W+1]};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R8: a control write lands in the stored fields
    assert_ctrl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl[g] |=> (pre_o[g] == $past(wdata[PRE_W-1:0])) && (sd_o[g] == $past(wdata[PRE_W])));
    // R9: a write addressed elsewhere leaves this channel's duty untouched
    assert_duty_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_duty[g] |=> $stable(dc_o[g]) && $stable(full_o[g]));
  end

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);

  logic [PRE_W-1:0] cnt;

  assign tick = !clr && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R1: the prescale count never passes its limit while running
  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt <= $past(limit)));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_cfg,
  input  logic             sd_cfg,
  input  logic [CNT_W-1:0] dc_cfg,
  input  logic             full_cfg,
  input  logic [CNT_W-1:0] pv_cfg,
  output logic             pwm_o
);

  logic             running;
  logic [CNT_W-1:0] per_cnt;
  logic [PRE_W-1:0] pre_act;
  logic [CNT_W-1:0] dc_act, pv_act;
  logic             full_act;
  logic             tick;

  // Named events for checks
  logic start_ev, period_end, abrupt_stop;
  assign start_ev    = !running && en;
  assign period_end  = running && tick && (per_cnt == pv_act);
  assign abrupt_stop = running && !en && sd_cfg;

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!running),
    .limit (pre_act),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      per_cnt  <= '0;
      pre_act  <= '0;
      dc_act   <= '0;
      pv_act   <= '0;
      full_act <= 1'b0;
    end else if (abrupt_stop) begin
      running <= 1'b0;
      per_cnt <= '0;
    end else if (start_ev || (period_end && en)) begin
      running  <= 1'b1;
      per_cnt  <= '0;
      pre_act  <= pre_cfg;
      dc_act   <= dc_cfg;
      pv_act   <= pv_cfg;
      full_act <= full_cfg;
    end else if (period_end) begin
      running <= 1'b0;
      per_cnt <= '0;
    end else if (running && tick) begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  assign pwm_o = running && duty_level(16'(per_cnt), 16'(dc_act), full_act);

  // R6: abrupt stop clears state on the next edge
  assert_abrupt_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abrupt_stop |=> !running && (per_cnt == '0));
  // R5: graceful mode keeps running until the period boundary
  assert_graceful_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !en && !sd_cfg && !period_end) |=> running);
  // R7: working settings only change at a boundary or a start
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !period_end) |=> $stable(dc_act) && $stable(pv_act) && $stable(pre_act) && $stable(full_act));
  // R1: the period count stays within its limit
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (per_cnt <= pv_act));

endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [NUM_CH-1:0][PRE_W-1:0] pre_cfg;
  logic [NUM_CH-1:0]            sd_cfg;
  logic [NUM_CH-1:0][CNT_W-1:0] dc_cfg;
  logic [NUM_CH-1:0]            full_cfg;
  logic [NUM_CH-1:0][CNT_W-1:0] pv_cfg;

  pwm_regfile #(
    .NUM_CH (NUM_CH), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .PRE_W  (PRE_W),  .CNT_W  (CNT_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .wr_en  (bus_wr),
    .rdata  (bus_rdata),
    .pre_o  (pre_cfg),
    .sd_o   (sd_cfg),
    .dc_o   (dc_cfg),
    .full_o (full_cfg),
    .pv_o   (pv_cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[c]),
      .pre_cfg  (pre_cfg[c]),
      .sd_cfg   (sd_cfg[c]),
      .dc_cfg   (dc_cfg[c]),
      .full_cfg (full_cfg[c]),
      .pv_cfg   (pv_cfg[c]),
      .pwm_o    (pwm_out[c])
    );
  end

  // R10: outputs are low out of reset
  assert_reset_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_out == '0));

endmodule

// File: tb/prescaled_pwm_tb.sv
module prescaled_pwm_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  ch_en = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_pwm u_dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_wr (bus_wr), .bus_rdata (bus_rdata), .ch_en (ch_en), .pwm_out (pwm_out)
  );

  // Waveform monitor
  int per_len [2];
  int hi_len  [2];
  int run_c   [2];
  int hi_run  [2];
  int rises   [2];
  bit prev    [2];

  initial for (int c = 0; c < 2; c++) begin
    per_len[c] = 0; hi_len[c] = 0; run_c[c] = 0; hi_run[c] = 0; rises[c] = 0; prev[c] = 0;
  end

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (pwm_out[c] && !prev[c]) begin
        per_len[c] = run_c[c];
        run_c[c]   = 1;
        hi_run[c]  = 1;
        rises[c]   = rises[c] + 1;
      end else begin
        run_c[c] = run_c[c] + 1;
        if (pwm_out[c]) hi_run[c] = hi_run[c] + 1;
        if (!pwm_out[c] && prev[c]) hi_len[c] = hi_run[c];
      end
      prev[c] = pwm_out[c];
    end
  end

  function automatic int exp_period(int p, int v);
    return (p + 1) * (v + 1);
  endfunction

  function automatic int exp_high(int p, int v, int d, bit full);
    if (full || d >= v + 1) return exp_period(p, v);
    return (p + 1) * d;
  endfunction

  task automatic report_summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, 190000);
      report_summary();
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(int addr, int data);
    bus_addr  = 5'(addr);
    bus_wdata = 32'(data);
    bus_wr    = 1'b1;
    step();
    bus_wr    = 1'b0;
  endtask

  task automatic rd(int addr, output int data);
    bus_addr = 5'(addr);
    #1;
    data = int'(bus_rdata);
  endtask

  task automatic wait_rises(int c, int n);
    int s;
    int guard;
    s = rises[c];
    guard = 0;
    while (rises[c] < s + n && guard < 5000) begin
      step();
      guard++;
    end
    if (guard >= 5000) check("wait for output edge", 0, 1);
  endtask

  task automatic count_high(int c, int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pwm_out[c]) hits++;
    end
  endtask

  task automatic stop_ch(int c);
    ch_en[c] = 1'b0;
    for (int i = 0; i < 1100; i++) step();
  endtask

  // Program one channel in graceful mode, run it, check one period
  task automatic check_wave(int c, int p, int v, int d, bit full, string tag);
    int base;
    int hits;
    int per;
    base = 16 * c;
    wr(base + 0, p);
    wr(base + 4, (int'(full) << 10) | d);
    wr(base + 8, v);
    per = exp_period(p, v);
    ch_en[c] = 1'b1;
    if (full || d == 0 || d >= v + 1) begin
      step(); step();
      count_high(c, 2 * per, hits);
      check({tag, " constant level (R3/R4)"}, hits, (d == 0 && !full) ? 0 : 2 * per);
    end else begin
      wait_rises(c, 2);
      check({tag, " period length R1"}, per_len[c], per);
      check({tag, " high time R2"}, hi_len[c], exp_high(p, v, d, full));
    end
    stop_ch(c);
  endtask

  initial begin
    int val;
    int hits;
    int r0;
    void'($urandom(32'd2024));
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R10 / R8: reset state
    check("R10 outputs low after reset", int'(pwm_out), 0);
    rd(5'h00, val); check("R8 ctrl0 reset", val, 0);
    rd(5'h04, val); check("R8 duty0 reset", val, 0);
    rd(5'h18, val); check("R8 period1 reset", val, 0);
    count_high(0, 20, hits); check("R10 idle ch0 low", hits, 0);

    // R8: field widths and unused bits
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, val); check("R8 ctrl fields", val, 32'h7F);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, val); check("R8 duty fields", val, 32'h7FF);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, val); check("R8 period field", val, 32'h3FF);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, val); check("R8 offset 0xC reads zero", val, 0);
    rd(5'h1C, val); check("R8 ch1 offset 0xC reads zero", val, 0);

    // R9: channel register independence
    wr(5'h04, 32'h155); wr(5'h14, 32'h2AA);
    rd(5'h04, val); check("R9 ch0 duty kept", val, 32'h155);
    rd(5'h14, val); check("R9 ch1 duty", val, 32'h2AA);

    // Directed waveforms
    check_wave(0, 1, 9, 4, 0, "R2 basic");
    check_wave(0, 63, 3, 2, 0, "R1 max prescale");
    check_wave(0, 0, 1023, 1023, 0, "R1 max period");
    check_wave(0, 2, 7, 0, 0, "R4 zero duty");
    check_wave(0, 2, 7, 8, 0, "R4 duty equals limit+1");
    check_wave(0, 1, 7, 0, 1, "R3 full flag over zero duty");
    check_wave(0, 1, 7, 3, 1, "R3 full flag");
    check_wave(1, 2, 5, 3, 0, "R9 channel 1");
    count_high(0, 30, hits); check("R9 ch0 idle while ch1 ran", hits, 0);

    // R5: graceful shutdown, period 20, high 8
    wr(5'h00, 1); wr(5'h04, 4); wr(5'h08, 9);
    ch_en[0] = 1'b1;
    wait_rises(0, 1);
    ch_en[0] = 1'b0;
    r0 = rises[0];
    count_high(0, 60, hits);
    check("R5 current period completes", hits, 7);
    check("R5 no new period", rises[0], r0);

    // R6: abrupt shutdown
    wr(5'h00, 32'h41);
    ch_en[0] = 1'b1;
    wait_rises(0, 1);
    ch_en[0] = 1'b0;
    count_high(0, 60, hits);
    check("R6 output low at once", hits, 0);
    ch_en[0] = 1'b1;
    wait_rises(0, 1);
    step(); step(); step();
    ch_en[0] = 1'b0;
    step(); step();
    ch_en[0] = 1'b1;
    wait_rises(0, 2);
    check("R6 restart gives full period", per_len[0], 20);
    check("R6 restart high time", hi_len[0], 8);
    ch_en[0] = 1'b0;
    step(); step();
    check("R6 low after abrupt stop", int'(pwm_out[0]), 0);

    // R7: shadowed updates, old 16/4 then new 32/24
    wr(5'h00, 0); wr(5'h04, 4); wr(5'h08, 15);
    ch_en[0] = 1'b1;
    wait_rises(0, 1);
    wr(5'h04, 12);
    wr(5'h00, 1);
    wait_rises(0, 1);
    check("R7 running period keeps old length", per_len[0], 16);
    check("R7 running period keeps old duty", hi_len[0], 4);
    wait_rises(0, 1);
    check("R7 new length after boundary", per_len[0], 32);
    check("R7 new duty after boundary", hi_len[0], 24);
    stop_ch(0);

    // Random settings
    for (int i = 0; i < 12; i++) begin
      int p, v, d, c;
      bit f;
      p = int'($urandom % 8);
      v = 1 + int'($urandom % 63);
      d = int'($urandom % (v + 2));
      f = ($urandom % 6) == 0;
      c = int'($urandom % 2);
      check_wave(c, p, v, d, f, "R1/R2 random");
    end

    done = 1;
    report_summary();
    $finish;
  end

endmodule